// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This unit compares two IEEE-754 single-precision operands, a destination and a source. It reports the outcome of (destination minus source) as a condition-code nibble and an exception status byte. The difference itself is never formed or stored. The only results are the sign and zero-ness that the subtraction would have, plus the unordered indication when a NaN takes part.

Each operand is classified as zero, denormal or normal (in range), infinity, quiet NaN or signaling NaN. A NaN on either side overrides the ordered result. The infinity flag is always driven low, because no branch condition built on a compare uses it. A one-cycle `valid_i` strobe captures the operands. The registered outputs and a `done_o` pulse appear on the next clock edge, and the outputs then hold until the next strobe.

Top module: `fp_cmp_cc`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `cc_o`, `exc_o` and `done_o` are all 0.
- R2: `done_o` is high for exactly the cycle after each cycle in which `valid_i` is high. `cc_o` and `exc_o` update only at that edge and keep their values while `valid_i` is low.
- R3: The infinity bit `cc_o[1]` is 0 after every compare, whatever the operands are.
- R4: If either operand is a NaN, `cc_o` is 4'b0001: the NaN bit `cc_o[0]` is set and N `cc_o[3]`, Z `cc_o[2]` and I are clear.
- R5: With no NaN present, Z (`cc_o[2]`) is set exactly when the operands are numerically equal. +0 and -0 are equal, and two infinities of the same sign are equal.
- R6: With no NaN present, N (`cc_o[3]`) is set when the destination is numerically less than the source, and also when both operands are negative infinity.
- R7: The signaling-NaN exception bit `exc_o[6]` is 1 exactly when at least one operand is a signaling NaN. Every other bit of `exc_o` is 0 after every compare.
- R8: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. The NaN is quiet when fraction bit 22 is 1 and signaling when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand strobe; captures a compare |
| src_i | input | 32 | Source operand, single precision |
| dst_i | input | 32 | Destination operand, single precision |
| done_o | output | 1 | High the cycle after a strobe |
| cc_o | output | 4 | Condition codes {N, Z, I, NAN} |
| exc_o | output | 8 | Exception status; bit 6 flags a signaling NaN |

## Verification
The assertions assume only that `valid_i` is a known level at every clock edge after reset. They assume nothing about how strobes are spaced. The stimulus changes inputs only at falling edges, so they are always stable and defined when sampled. Back-to-back strobes are allowed. Hold intervals, in which operands change while `valid_i` stays low, are placed between compares to exercise the no-update rule.

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [31:0] src_i,
  input  logic [31:0] dst_i,
  output logic        done_o,
  output logic [3:0]  cc_o,
  output logic [7:0]  exc_o
);
  localparam int EW = 8;
  localparam int FW = 23;

  logic s_nan, d_nan, s_snan, d_snan, s_zero, d_zero, s_ninf, d_ninf;
  logic any_nan, any_snan, same, mag_lt, mag_gt, d_less;
  logic [3:0] cc_n;

  assign s_nan  = (&src_i[30:FW]) && (|src_i[FW-1:0]);
  assign d_nan  = (&dst_i[30:FW]) && (|dst_i[FW-1:0]);
  assign s_snan = s_nan && !src_i[FW-1];
  assign d_snan = d_nan && !dst_i[FW-1];
  assign s_zero = ~|src_i[30:0];
  assign d_zero = ~|dst_i[30:0];
  assign s_ninf = src_i[31] && (&src_i[30:FW]) && ~|src_i[FW-1:0];
  assign d_ninf = dst_i[31] && (&dst_i[30:FW]) && ~|dst_i[FW-1:0];

  assign any_nan  = s_nan || d_nan;
  assign any_snan = s_snan || d_snan;
  assign same     = (s_zero && d_zero) || (src_i == dst_i);
  assign mag_lt   = dst_i[30:0] < src_i[30:0];
  assign mag_gt   = dst_i[30:0] > src_i[30:0];

  always_comb begin
    if (same)                      d_less = 1'b0;
    else if (dst_i[31] != src_i[31]) d_less = dst_i[31];
    else if (dst_i[31])            d_less = mag_gt;
    else                           d_less = mag_lt;
  end

  assign cc_n = any_nan ? 4'b0001
                        : {d_less || (s_ninf && d_ninf), same, 1'b0, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      cc_o   <= '0;
      exc_o  <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        cc_o  <= cc_n;
        exc_o <= {1'b0, any_snan, {(EW-2){1'b0}}};
      end
    end
  end
endmodule

// File: rtl/fp_cmp_cc_chk.sv
module fp_cmp_cc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       done_o,
  input logic [3:0] cc_o,
  input logic [7:0] exc_o
);
  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(cc_o) && $stable(exc_o)));
  a_r3_inf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_o[1]);
  a_r4_nan_excl: assert property (@(posedge clk) disable iff (!rst_n)
    cc_o[0] |-> (cc_o[3:1] == 3'b000));
  a_r7_exc_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_o & 8'hBF) == 8'h00);
  a_r7_snan_nan: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o[6] |-> cc_o[0]);
endmodule

bind fp_cmp_cc fp_cmp_cc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
  .done_o(done_o), .cc_o(cc_o), .exc_o(exc_o)
);

// File: tb/fp_cmp_cc_tb_top.sv
module fp_cmp_cc_tb_top;
  localparam time CLK_P = 10;
  localparam int  NV = 16;

  logic clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic done_o;
  logic [3:0] cc_o;
  logic [7:0] exc_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] vals [NV];

  always #(CLK_P/2) clk = ~clk;

  fp_cmp_cc dut_i (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i),
                   .dst_i(dst_i), .done_o(done_o), .cc_o(cc_o), .exc_o(exc_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic logic signed [33:0] key(input logic [31:0] x);
    logic signed [33:0] m;
    m = $signed({3'b000, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  initial begin
    #(CLK_P*200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vals = '{32'h00000000, 32'h80000000, 32'h00000001, 32'h807FFFFF,
             32'h3F800000, 32'h40000000, 32'hBF800000, 32'hC0000000,
             32'h7F7FFFFF, 32'hFF7FFFFF, 32'h7F800000, 32'hFF800000,
             32'h7FC00000, 32'hFFC00001, 32'h7F800001, 32'hFFA00000};
    #(CLK_P*3);
    @(negedge clk);
    chk(cc_o == 0 && exc_o == 0 && done_o == 0, "R1 reset",
        {20'd0, done_o, exc_o, cc_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cc_o == 0 && exc_o == 0 && done_o == 0, "R1 post-reset",
        {20'd0, done_o, exc_o, cc_o}, 0);
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        logic [3:0] ecc;
        logic [7:0] eex;
        bit nan, sn;
        nan = is_nan(vals[i]) || is_nan(vals[j]);
        sn  = (is_nan(vals[i]) && !vals[i][22]) || (is_nan(vals[j]) && !vals[j][22]);
        if (nan) ecc = 4'b0001;
        else begin
          ecc[2] = key(vals[i]) == key(vals[j]);
          ecc[3] = key(vals[i]) < key(vals[j]) ||
                   (vals[i] == 32'hFF800000 && vals[j] == 32'hFF800000);
          ecc[1:0] = 2'b00;
        end
        eex = sn ? 8'h40 : 8'h00;
        dst_i = vals[i]; src_i = vals[j]; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk(done_o, "R2 done", {31'd0, done_o}, 1);
        chk(!cc_o[1], "R3 inf bit", {28'd0, cc_o}, {28'd0, ecc});
        if (nan) chk(cc_o == ecc, "R4 R8 nan override", {28'd0, cc_o}, {28'd0, ecc});
        else begin
          chk(cc_o[2] == ecc[2], "R5 zero", {28'd0, cc_o}, {28'd0, ecc});
          chk(cc_o[3] == ecc[3], "R6 negative", {28'd0, cc_o}, {28'd0, ecc});
        end
        chk(exc_o == eex, "R7 R8 exception", {24'd0, exc_o}, {24'd0, eex});
        if ((i + j) % 5 == 0) begin
          logic [3:0] hcc;
          logic [7:0] hex;
          hcc = cc_o; hex = exc_o;
          dst_i = vals[(i+7)%NV]; src_i = vals[(j+3)%NV];
          @(negedge clk);
          chk(!done_o && cc_o == hcc && exc_o == hex, "R2 hold",
              {20'd0, done_o, exc_o, cc_o}, {20'd0, 1'b0, hex, hcc});
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule